// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache with Timed Line Fill

This block sits between a processor word port and a slower memory bus. It keeps a small number of lines, one per row, and each row has a stored tag and a valid bit. The processor raises a request with an address, a direction and write data. The cache answers with a single-cycle ready pulse. A read whose row holds the matching tag is answered from the cache. A read that misses starts a line fill on the memory bus. The fill spends a fixed number of address-setup cycles and then a fixed number of cycles on each bus beat. It loads the whole line, installs the new tag and then returns the requested word. The miss latency is therefore a known constant.

Writes always go to memory through a single-cycle bus write. When the addressed line is already held in the cache, the cached word is updated in the same step. A write that misses leaves the cache unchanged. The processor holds its request stable until it sees ready. A request that is still asserted while a fill runs is not sampled again.

The controller has four states. S_IDLE waits for a request. S_FILL runs the burst. S_RESP presents read data with ready. S_WRITE drives the bus write with ready. The transitions are:
- S_IDLE to S_RESP on a read hit.
- S_IDLE to S_FILL on a read miss.
- S_IDLE to S_WRITE on any write.
- S_FILL to S_RESP when the last beat is taken.
- S_RESP and S_WRITE both return to S_IDLE.

Top module: `wt_dm_cache`

## Requirements
- R1: With the default parameters (16-bit byte address, 512-byte cache, 64-byte lines, 32-bit words), the address fields are:
  - the tag is address bits [15:9];
  - the row is bits [8:6];
  - the word within the line is bits [5:2];
  - bits [1:0] are ignored, so two addresses that differ only there return the same word and both hit once the line is loaded.
- R2: After reset, ready, the bus read strobe and the bus write strobe are low, and every row is invalid. The first read of any address is therefore a miss.
- R3: Ready is high in the first cycle after a read hit is sampled, with the stored word on the read data output. No bus read takes place.
- R4: A read miss keeps the bus read strobe high for 37 cycles: 5 setup cycles followed by 16 beats of 2 cycles each. Beat k presents the line base address plus 4·k, in ascending order from word 0. Ready rises in the 38th cycle after the request is sampled, with the requested word on the read data output.
- R5: After a fill, every word of that line is a hit.
- R6: A fill overwrites the row's tag. A later read of the line that was displaced from that row misses.
- R7: A write raises the bus write strobe for exactly one cycle, with the word-aligned address and the write data on the bus. Ready is high in that same cycle, which is the first cycle after the request is sampled.
- R8: A write to a cached line updates the cached word, so the next read of that address hits and returns the new data.
- R9: A write that misses does not allocate a line. A read of that address afterwards misses and returns the value written.
- R10: Ready is a one-cycle pulse. The block is idle in the cycle after it, and a request held during a fill is accepted only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with ready |
| bus_rd | output | 1 | Fill in progress (setup and beats) |
| bus_we | output | 1 | One-cycle memory write strobe |
| bus_addr | output | ADDR_W | Beat address during fill, write address during write |
| bus_wdata | output | DATA_W | Memory write data |
| bus_rdata | input | DATA_W | Memory beat data, taken at the last cycle of each beat |

## Verification
On one clock edge, the fill writes a beat into the line store and may also capture that same word into the response register. When the beat is the last one, that edge also installs the new tag and moves the controller to S_RESP. The bench provokes this in two ways. It reads a word in the middle of a line, and it reads the final word of a line (address 0xFFFC), so the capture falls on an inner beat and on the closing beat. The cycle-by-cycle model judges each case by the returned word. It then requires an immediate hit on a neighbouring address of the same line, with no bus activity.

// File: rtl/wt_dm_pkg.sv
package wt_dm_pkg;

    // Controller states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_RESP  = 2'd2,
        S_WRITE = 2'd3
    } ctl_state_e;

    // Fill sequencer phases
    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_SETUP = 2'd1,
        F_BEAT  = 2'd2
    } fill_phase_e;

endpackage

// File: rtl/wt_dm_tags.sv
module wt_dm_tags #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] lk_row,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             al_en,
    input  logic [ROW_W-1:0] al_row,
    input  logic [TAG_W-1:0] al_tag
);

    logic [ROWS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (al_en) begin
            vld_q[al_row] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (al_en) begin
            tag_q[al_row] <= al_tag;
        end
    end

    assign lk_hit = vld_q[lk_row] && (tag_q[lk_row] == lk_tag);

endmodule

// File: rtl/wt_dm_data.sv
module wt_dm_data #(
    parameter int ROWS   = 8,
    parameter int WPL    = 16,
    parameter int ROW_W  = 3,
    parameter int WIDX_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [WIDX_W-1:0] rd_widx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_we,
    input  logic [ROW_W-1:0]  fill_row,
    input  logic [WIDX_W-1:0] fill_widx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_we,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [WIDX_W-1:0] upd_widx,
    input  logic [DATA_W-1:0] upd_data
);

    localparam int DEPTH = ROWS * WPL;

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            word_q[{fill_row, fill_widx}] <= fill_data;
        end else if (upd_we) begin
            word_q[{upd_row, upd_widx}] <= upd_data;
        end
    end

    assign rd_data = word_q[{rd_row, rd_widx}];

    // R8: a write-hit update never collides with a fill beat
    a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_we && upd_we));

endmodule

// File: rtl/wt_dm_fill.sv
module wt_dm_fill
    import wt_dm_pkg::*;
#(
    parameter int SETUP_CYC = 5,
    parameter int BEAT_CYC  = 2,
    parameter int BEATS     = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             beat_take,
    output logic [IDX_W-1:0] beat_idx,
    output logic             fill_last
);

    localparam int CMAX  = (SETUP_CYC > BEAT_CYC) ? SETUP_CYC : BEAT_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int SPAN  = SETUP_CYC + BEATS * BEAT_CYC;

    fill_phase_e      ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= F_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (ph_q)
                F_IDLE: begin
                    if (start) begin
                        ph_q  <= F_SETUP;
                        cnt_q <= CNT_W'(SETUP_CYC - 1);
                        idx_q <= '0;
                    end
                end
                F_SETUP: begin
                    if (cnt_q == '0) begin
                        ph_q  <= F_BEAT;
                        cnt_q <= CNT_W'(BEAT_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                F_BEAT: begin
                    if (cnt_q == '0) begin
                        if (idx_q == IDX_W'(BEATS - 1)) begin
                            ph_q <= F_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            cnt_q <= CNT_W'(BEAT_CYC - 1);
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= F_IDLE;
            endcase
        end
    end

    assign busy      = (ph_q != F_IDLE);
    assign beat_take = (ph_q == F_BEAT) && (cnt_q == '0);
    assign beat_idx  = idx_q;
    assign fill_last = beat_take && (idx_q == IDX_W'(BEATS - 1));

    // Checker: cycles elapsed since the fill started
    logic [15:0] el_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el_q <= '0;
        end else if (start) begin
            el_q <= '0;
        end else if (busy) begin
            el_q <= el_q + 16'd1;
        end
    end

    // R4: the last beat lands exactly at setup plus all beat cycles
    a_r4_fill_span: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |-> (el_q == 16'(SPAN - 1)));

    // R10: no new fill is started while one is running
    a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
    import wt_dm_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int CACHE_BYTES = 512,
    parameter int SETUP_CYC   = 5,
    parameter int BEAT_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_rd,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BYTE_OFS   = $clog2(WORD_BYTES);
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WPL        = LINE_BYTES / WORD_BYTES;
    localparam int WIDX_W     = OFS_W - BYTE_OFS;
    localparam int ROWS       = CACHE_BYTES / LINE_BYTES;
    localparam int ROW_W      = $clog2(ROWS);
    localparam int TAG_W      = ADDR_W - OFS_W - ROW_W;

    ctl_state_e st_q, st_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Address fields
    logic [TAG_W-1:0]  in_tag, q_tag;
    logic [ROW_W-1:0]  in_row, q_row;
    logic [WIDX_W-1:0] in_widx, q_widx;

    assign in_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign in_row  = cpu_addr[OFS_W +: ROW_W];
    assign in_widx = cpu_addr[BYTE_OFS +: WIDX_W];
    assign q_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign q_row   = addr_q[OFS_W +: ROW_W];
    assign q_widx  = addr_q[BYTE_OFS +: WIDX_W];

    logic              hit;
    logic              accept;
    logic              fill_start;
    logic              fill_busy;
    logic              beat_take;
    logic              fill_last;
    logic [WIDX_W-1:0] beat_idx;
    logic [DATA_W-1:0] rd_data;
    logic              upd_we;

    assign accept     = (st_q == S_IDLE) && cpu_req;
    assign fill_start = accept && !cpu_we && !hit;
    assign upd_we     = accept && cpu_we && hit;

    wt_dm_tags #(
        .ROWS (ROWS),
        .ROW_W(ROW_W),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_row(in_row),
        .lk_tag(in_tag),
        .lk_hit(hit),
        .al_en (fill_last),
        .al_row(q_row),
        .al_tag(q_tag)
    );

    wt_dm_data #(
        .ROWS  (ROWS),
        .WPL   (WPL),
        .ROW_W (ROW_W),
        .WIDX_W(WIDX_W),
        .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_row   (in_row),
        .rd_widx  (in_widx),
        .rd_data  (rd_data),
        .fill_we  (beat_take),
        .fill_row (q_row),
        .fill_widx(beat_idx),
        .fill_data(bus_rdata),
        .upd_we   (upd_we),
        .upd_row  (in_row),
        .upd_widx (in_widx),
        .upd_data (cpu_wdata)
    );

    wt_dm_fill #(
        .SETUP_CYC(SETUP_CYC),
        .BEAT_CYC (BEAT_CYC),
        .BEATS    (WPL),
        .IDX_W    (WIDX_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fill_start),
        .busy     (fill_busy),
        .beat_take(beat_take),
        .beat_idx (beat_idx),
        .fill_last(fill_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we)   st_d = S_WRITE;
                    else if (hit) st_d = S_RESP;
                    else          st_d = S_FILL;
                end
            end
            S_FILL:  if (fill_last) st_d = S_RESP;
            S_RESP:  st_d = S_IDLE;
            S_WRITE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // Request and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                if (!cpu_we && hit) begin
                    rdata_q <= rd_data;
                end
            end
            if (beat_take && (beat_idx == q_widx)) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_ready = (st_q == S_RESP) || (st_q == S_WRITE);
        cpu_rdata = rdata_q;
        bus_rd    = fill_busy;
        bus_we    = (st_q == S_WRITE);
        bus_wdata = wdata_q;
        if (st_q == S_WRITE) begin
            bus_addr = addr_q & ~ADDR_W'(WORD_BYTES - 1);
        end else begin
            bus_addr = {addr_q[ADDR_W-1:OFS_W], beat_idx, {BYTE_OFS{1'b0}}};
        end
    end

    // R10: ready lasts one cycle
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R7: a bus write is acknowledged in the same cycle and never overlaps a fill
    a_r7_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (cpu_ready && !bus_rd));

    // R3: a read hit answers next cycle without bus traffic
    a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && cpu_req && !cpu_we && hit) |=> (cpu_ready && !bus_rd));

    // R9: a tag is installed only by a read fill
    a_r9_alloc_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |-> (st_q == S_FILL));

endmodule

// File: tb/wt_dm_cache_tb.sv
`timescale 1ns/1ps
module wt_dm_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [15:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bus_rd, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    logic [31:0] wmem [logic [15:0]];
    bit          mv [8];
    logic [6:0]  mt [8];

    always #4 clk = ~clk;

    wt_dm_cache u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .bus_rd   (bus_rd),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return {a ^ 16'h5A5A, a};
    endfunction

    // Memory model: beat data presented half a cycle ahead of the capture edge
    always @(negedge clk) bus_rdata <= mem_word(bus_addr);
    always @(posedge clk) if (bus_we) wmem[bus_addr] = bus_wdata;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic xact(input bit w, input logic [15:0] a, input logic [31:0] d,
                        input string rt, input string rd);
        logic [2:0]  r    = a[8:6];
        logic [6:0]  t    = a[15:9];
        bit          hit  = mv[r] && (mt[r] == t);
        bit          miss = !w && !hit;
        int          lat  = miss ? 38 : 1;
        logic [15:0] wa   = {a[15:2], 2'b00};
        logic [15:0] ba   = {a[15:6], 6'b000000};
        logic [15:0] eba;
        logic [31:0] expd;
        cpu_req   = 1'b1;
        cpu_we    = w;
        cpu_addr  = a;
        cpu_wdata = d;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            check(cpu_ready == (k == lat), rt, "ready", 32'(cpu_ready), 32'(k == lat));
            check(bus_rd == (miss && k < lat), rt, "bus read", 32'(bus_rd), 32'(miss && k < lat));
            check(bus_we == (w && k == 1), rt, "bus write", 32'(bus_we), 32'(w && k == 1));
            if (miss && k >= 6 && k <= 37) begin
                eba = ba + 16'(4 * ((k - 6) / 2));
                check(bus_addr == eba, "R4", "beat address", 32'(bus_addr), 32'(eba));
            end
            if (w && k == 1) begin
                check(bus_addr == wa, "R7", "write address", 32'(bus_addr), 32'(wa));
                check(bus_wdata == d, "R7", "write data", bus_wdata, d);
            end
        end
        if (!w) begin
            expd = mem_word(wa);
            check(cpu_rdata == expd, rd, "read data", cpu_rdata, expd);
        end
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !bus_rd && !bus_we, "R10", "idle after response",
              {29'd0, cpu_ready, bus_rd, bus_we}, 32'd0);
        if (miss) begin
            mv[r] = 1'b1;
            mt[r] = t;
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        cpu_req   = 1'b0;
        cpu_we    = 1'b0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        for (int i = 0; i < 8; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R2: outputs quiet in reset
        check(!cpu_ready && !bus_rd && !bus_we, "R2", "reset outputs",
              {29'd0, cpu_ready, bus_rd, bus_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        xact(1'b0, 16'h0040, 32'd0, "R2", "R4");        // first access misses
        xact(1'b0, 16'h0078, 32'd0, "R5", "R5");        // same line hits
        xact(1'b0, 16'h007C, 32'd0, "R3", "R5");
        xact(1'b0, 16'h0040, 32'd0, "R3", "R3");
        xact(1'b0, 16'h0240, 32'd0, "R6", "R6");        // same row, new tag
        xact(1'b0, 16'h0044, 32'd0, "R6", "R6");        // displaced line misses
        xact(1'b1, 16'h0050, 32'hDEADBEEF, "R7", "R7"); // write hit
        xact(1'b0, 16'h0050, 32'd0, "R8", "R8");        // reads new data as hit
        xact(1'b1, 16'h3000, 32'h12345678, "R9", "R9"); // write miss
        xact(1'b0, 16'h3000, 32'd0, "R9", "R9");        // still a miss, sees written value
        xact(1'b0, 16'h0A2C, 32'd0, "R4", "R4");        // mid-line word
        xact(1'b0, 16'h0A00, 32'd0, "R5", "R5");
        xact(1'b0, 16'hFFFC, 32'd0, "R4", "R1");        // last word of line, top tag
        xact(1'b0, 16'hFFFD, 32'd0, "R1", "R1");        // byte bits ignored
        xact(1'b0, 16'hFFC2, 32'd0, "R5", "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule